// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block holds four critical control registers: power-save control, processor clock control, watchdog mode and backup power status. Runaway code should not be able to overwrite them. The registers sit on a simple synchronous register bus with one shared address, a write enable, write data, a write operation code, a read enable and registered read data.

A guarded register changes only when the bus write directly before it went to a dedicated, write-only command register. Any other write attempt to a guarded register leaves the register unchanged and sets a sticky error flag in a status register. Software clears the flag by writing 1 to its bit. Reads are never restricted.

The bus carries the writes of every master. Any write in the unlock window, from any master, ends that window. Software must keep other masters quiet while it performs the two-write sequence.

Top module: `prot_wr_guard`

## Requirements
- R1: Address map:
  - Addresses 0, 1, 2 and 3 are the guarded power-save, clock, watchdog and backup registers.
  - Address 4 is the status register, with the error flag in bit 0 and the other bits reading 0.
  - Address 5 is the command register.
  - Reads of any other address return 0.
- R2: A write to a guarded register takes effect at the clock edge of that write only when the previous bus write targeted the command register.
- R3: A write to a guarded register that does not directly follow a command-register write leaves the register unchanged and sets the error flag.
- R4: The error flag stays set until a status write with bit 0 equal to 1 clears it. A status write with bit 0 equal to 0 leaves it unchanged.
- R5: The unlock is ended by the next bus write to any address, whether or not that write succeeds. Writes that end it include guarded, status, unmapped and failed writes. A command-register write re-arms it.
- R6: wr_op selects how a guarded write combines wr_data with the old contents:
  - 0 replaces the contents.
  - 1 sets the bits that are 1 in wr_data.
  - 2 clears the bits that are 1 in wr_data.
  - 3 inverts the bits that are 1 in wr_data.

  Every code obeys the unlock rule.
- R7: The command register reads as 0. Any data value written to it arms the unlock.
- R8: A read with rd_en high returns the current contents of the addressed register on rd_data after the next clock edge, with no unlock needed. rd_data holds its value when rd_en is low. Reads neither arm nor end the unlock.
- R9: After reset the registers hold their defaults:
  - power-save 0x00
  - clock 0x03
  - watchdog 0x1F
  - backup 0x80

  After reset the error flag is 0, the unlock is disarmed and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address for the read or write |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Write combine code (replace, set, clear, invert) |
| wr_data | input | 8 | Write data or bit mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The unlock flag and the error flag are internal. A wrong unlock state shows one write later, as a guarded register that does or does not change on read-back. It also shows as a status read whose error bit disagrees with the write history.

The bench therefore reads back after each sequence of interest. Those sequences are:
- a failed write
- a double command write
- a status or unmapped write placed between command and target
- each combine code

A read-path fault shows on rd_data on the edge after the read strobe, starting with the reset readings.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef enum logic [1:0] {
    OP_PUT = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_INV = 2'd3
  } wr_op_e;
endpackage

// File: rtl/prw_decode.sv
module prw_decode #(
  parameter int ADDR_W     = 4,
  parameter int N_GUARD    = 4,
  parameter int GUARD_BASE = 0,
  parameter int STAT_ADDR  = 4,
  parameter int CMD_ADDR   = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_GUARD-1:0] hit_guard,
  output logic               hit_stat,
  output logic               hit_cmd
);
  for (genvar i = 0; i < N_GUARD; i++) begin : g_hit
    assign hit_guard[i] = (addr == ADDR_W'(GUARD_BASE + i));
  end
  assign hit_stat = (addr == ADDR_W'(STAT_ADDR));
  assign hit_cmd  = (addr == ADDR_W'(CMD_ADDR));
endmodule

// File: rtl/prw_unlock.sv
module prw_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic hit_cmd,
  output logic armed_q
);
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (wr_en) armed_d = hit_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/prw_bank.sv
module prw_bank
  import prw_pkg::*;
#(
  parameter int                        DATA_W   = 8,
  parameter int                        N_GUARD  = 4,
  parameter logic [N_GUARD*DATA_W-1:0] RST_VALS = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [N_GUARD-1:0]        hit_guard,
  input  logic [1:0]                wr_op,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [N_GUARD*DATA_W-1:0] bank_q
);
  for (genvar i = 0; i < N_GUARD; i++) begin : g_reg
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] cur_d;
    logic              en;

    assign en = accept & hit_guard[i];

    always_comb begin
      cur_d = cur_q;
      if (en) begin
        case (wr_op_e'(wr_op))
          OP_PUT:  cur_d = wr_data;
          OP_SET:  cur_d = cur_q | wr_data;
          OP_CLR:  cur_d = cur_q & ~wr_data;
          default: cur_d = cur_q ^ wr_data;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= RST_VALS[i*DATA_W +: DATA_W];
      else        cur_q <= cur_d;
    end

    assign bank_q[i*DATA_W +: DATA_W] = cur_q;
  end
endmodule

// File: rtl/prw_status.sv
module prw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic illegal,
  input  logic clr_req,
  output logic err_q
);
  logic err_d;

  always_comb begin
    err_d = err_q;
    if (illegal)      err_d = 1'b1;
    else if (clr_req) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/prot_wr_guard.sv
module prot_wr_guard #(
  parameter int                        ADDR_W     = 4,
  parameter int                        DATA_W     = 8,
  parameter int                        N_GUARD    = 4,
  parameter int                        GUARD_BASE = 0,
  parameter int                        STAT_ADDR  = 4,
  parameter int                        CMD_ADDR   = 5,
  parameter int                        ERR_BIT    = 0,
  parameter logic [N_GUARD*DATA_W-1:0] RST_VALS   = 32'h801F_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [N_GUARD-1:0]        hit_guard;
  logic                      hit_stat;
  logic                      hit_cmd;
  logic                      armed_q;
  logic                      guard_wr;
  logic                      accept;
  logic                      illegal;
  logic                      clr_req;
  logic                      err_q;
  logic [N_GUARD*DATA_W-1:0] bank_q;
  logic [DATA_W-1:0]         rd_d;
  logic [DATA_W-1:0]         rd_q;

  prw_decode #(
    .ADDR_W(ADDR_W), .N_GUARD(N_GUARD), .GUARD_BASE(GUARD_BASE),
    .STAT_ADDR(STAT_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .addr(addr), .hit_guard(hit_guard), .hit_stat(hit_stat), .hit_cmd(hit_cmd)
  );

  prw_unlock u_unl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_cmd(hit_cmd), .armed_q(armed_q)
  );

  assign guard_wr = wr_en & (|hit_guard);
  assign accept   = guard_wr & armed_q;
  assign illegal  = guard_wr & ~armed_q;
  assign clr_req  = wr_en & hit_stat & wr_data[ERR_BIT];

  prw_bank #(
    .DATA_W(DATA_W), .N_GUARD(N_GUARD), .RST_VALS(RST_VALS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hit_guard(hit_guard),
    .wr_op(wr_op), .wr_data(wr_data), .bank_q(bank_q)
  );

  prw_status u_stat (
    .clk(clk), .rst_n(rst_n), .illegal(illegal), .clr_req(clr_req), .err_q(err_q)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      for (int i = 0; i < N_GUARD; i++) begin
        if (hit_guard[i]) rd_d = bank_q[i*DATA_W +: DATA_W];
      end
      if (hit_stat) rd_d[ERR_BIT] = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

module prw_checker #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int N_GUARD   = 4,
  parameter int STAT_ADDR = 4,
  parameter int CMD_ADDR  = 5,
  parameter int ERR_BIT   = 0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         addr,
  input logic                      wr_en,
  input logic [DATA_W-1:0]         wr_data,
  input logic                      rd_en,
  input logic [DATA_W-1:0]         rd_data,
  input logic [N_GUARD-1:0]        hit_guard,
  input logic                      armed_q,
  input logic                      err_q,
  input logic [N_GUARD*DATA_W-1:0] bank_q
);
  // R3: a locked guarded write changes nothing in the bank
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|hit_guard) && !armed_q) |=> $stable(bank_q));

  // R3: a locked guarded write raises the error flag
  a_r3_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|hit_guard) && !armed_q) |=> err_q);

  // R4: the flag stays set unless a clearing status write occurs
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_en && addr == ADDR_W'(STAT_ADDR) && wr_data[ERR_BIT])) |=> err_q);

  // R5: any write not aimed at the command register ends the unlock
  a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADDR_W'(CMD_ADDR)) |=> !armed_q);

  // R7: reads of the command register return zero
  a_r7_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CMD_ADDR)) |=> (rd_data == '0));

  // R8: cycles without a write leave the unlock state alone
  a_r8_no_write_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(armed_q));

  // R8: rd_data holds while no read is issued
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind prot_wr_guard prw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GUARD(N_GUARD),
  .STAT_ADDR(STAT_ADDR), .CMD_ADDR(CMD_ADDR), .ERR_BIT(ERR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .hit_guard(hit_guard), .armed_q(armed_q),
  .err_q(err_q), .bank_q(bank_q)
);

// File: tb/tb_prot_wr_guard.sv
module tb_prot_wr_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_PSV = 4'd0, A_CLK = 4'd1, A_WDG = 4'd2, A_BKP = 4'd3;
  localparam logic [3:0] A_STA = 4'd4, A_CMD = 4'd5, A_UNM = 4'd7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en;
  logic [1:0] wr_op;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  prot_wr_guard dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_op(wr_op),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: a read seen at an edge is compared just after that edge
  always @(posedge clk) begin
    logic was_rd;
    was_rd = rd_en & rst_n;
    #1;
    if (was_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_op = op; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; wr_en = 1'b0; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_op = '0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R9: reset rd_data=%02h expected=00", rd_data);
    end
    rst_n = 1'b1;
    // R9 / R1 / R7 reset contents and map
    rd(A_PSV, 8'h00, "R9 psave default");
    rd(A_CLK, 8'h03, "R9 clock default");
    rd(A_WDG, 8'h1F, "R9 watchdog default");
    rd(A_BKP, 8'h80, "R9 backup default");
    rd(A_STA, 8'h00, "R9 error clear");
    rd(A_CMD, 8'h00, "R7 command reads zero");
    rd(A_UNM, 8'h00, "R1 unmapped reads zero");
    // R9 unlock disarmed after reset -> R3 illegal
    wr(A_PSV, 2'd0, 8'h55);
    rd(A_PSV, 8'h00, "R3 locked write ignored");
    rd(A_STA, 8'h01, "R3 error set");
    // R4
    wr(A_STA, 2'd0, 8'hFE);
    rd(A_STA, 8'h01, "R4 write 0 keeps flag");
    wr(A_STA, 2'd0, 8'h01);
    rd(A_STA, 8'h00, "R4 write 1 clears flag");
    // R2
    wr(A_CMD, 2'd0, 8'hA5);
    wr(A_PSV, 2'd0, 8'h55);
    rd(A_PSV, 8'h55, "R2 unlocked write");
    rd(A_STA, 8'h00, "R2 no error");
    // R8 reads between command and target keep unlock
    wr(A_CMD, 2'd0, 8'h00);
    rd(A_CLK, 8'h03, "R8 read without unlock");
    rd(A_CMD, 8'h00, "R7 command read after arm");
    wr(A_CLK, 2'd0, 8'h0C);
    rd(A_CLK, 8'h0C, "R8 reads do not disarm");
    // R5 unmapped write cancels
    wr(A_CMD, 2'd0, 8'h3C);
    wr(A_UNM, 2'd0, 8'h00);
    wr(A_WDG, 2'd0, 8'h00);
    rd(A_WDG, 8'h1F, "R5 unmapped write cancels");
    rd(A_STA, 8'h01, "R5 error after cancel");
    wr(A_STA, 2'd0, 8'h01);
    // R5 unlock consumed by a success
    wr(A_CMD, 2'd0, 8'h77);
    wr(A_BKP, 2'd0, 8'h81);
    wr(A_BKP, 2'd0, 8'h01);
    rd(A_BKP, 8'h81, "R5 second write refused");
    rd(A_STA, 8'h01, "R5 error on second write");
    wr(A_STA, 2'd0, 8'h01);
    // R5 command twice stays armed
    wr(A_CMD, 2'd0, 8'h01);
    wr(A_CMD, 2'd0, 8'h02);
    wr(A_WDG, 2'd0, 8'h0F);
    rd(A_WDG, 8'h0F, "R5 re-armed by command");
    // R5 status write cancels
    wr(A_CMD, 2'd0, 8'h00);
    wr(A_STA, 2'd0, 8'h00);
    wr(A_PSV, 2'd0, 8'hAA);
    rd(A_PSV, 8'h55, "R5 status write cancels");
    rd(A_STA, 8'h01, "R5 error after status cancel");
    wr(A_STA, 2'd0, 8'h01);
    // R6 combine codes
    wr(A_CMD, 2'd0, 8'h00);
    wr(A_PSV, 2'd1, 8'h0A);
    rd(A_PSV, 8'h5F, "R6 set bits");
    wr(A_CMD, 2'd0, 8'h00);
    wr(A_PSV, 2'd2, 8'h0F);
    rd(A_PSV, 8'h50, "R6 clear bits");
    wr(A_CMD, 2'd0, 8'h00);
    wr(A_PSV, 2'd3, 8'hF0);
    rd(A_PSV, 8'hA0, "R6 invert bits");
    wr(A_PSV, 2'd1, 8'h0F);
    rd(A_PSV, 8'hA0, "R6 locked set refused");
    rd(A_STA, 8'h01, "R6 locked set flags error");
    idle();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule